// File: doc/BRIEF.md
# Accumulator OR / Subtract-with-Borrow / Rotate Unit

This block is the accumulator slice of an 8-bit processor's execution unit. It covers three operation classes: bitwise OR, subtract with borrow, and the four one-bit rotates of the accumulator, two circular and two through the carry. The sequencer presents an opcode together with the current accumulator, an operand byte and the current flags byte, and pulses `start` for one cycle. The unit works out where the operand comes from, spends the instruction's T-state budget, and then commits the new accumulator and the new flags byte in one cycle, marked by `done`.

The operand source is decoded from the low three opcode bits and shown on `srcSel` in the same cycle, so the sequencer knows which byte to supply. The sequencer also does the memory fetch and the register-file write. When the source is the accumulator itself, the unit uses `accIn` and ignores `operand`. Each operation class writes its own subset of flags. OR clears the two carry flags. The rotates change only the carry. Subtraction takes in the incoming carry as a borrow and rewrites every flag.

Top module: `acc_alu_unit`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `accOut` and `flagsOut` are 0 and `busy` and `done` are low. This holds even if reset arrives in the middle of an operation.
- R2: OR (opcodes 8'hB0 to 8'hB7 and immediate 8'hF6) produces `accIn | operand`. The flags byte uses bit 7 = sign, bit 6 = zero, bit 4 = half borrow (AC), bit 2 = parity and bit 0 = carry, with bits 5, 3 and 1 always 0. For OR, sign is result bit 7, zero is 1 for a zero result, parity is 1 for an even count of ones, and AC and carry are 0.
- R3: Subtract with borrow (opcodes 8'h98 to 8'h9F and immediate 8'hDE) produces `accIn - operand - CYin` modulo 256, where CYin is `flagsIn` bit 0. Carry is the borrow out of bit 7 and AC is the borrow out of bit 3. Sign, zero and parity follow the R2 rules.
- R4: Rotate left through carry (8'h17) moves bit 7 into carry and the old carry into bit 0. Rotate right through carry (8'h1F) moves bit 0 into carry and the old carry into bit 7.
- R5: Rotate left circular (8'h07) copies bit 7 into bit 0 and into carry. Rotate right circular (8'h0F) copies bit 0 into bit 7 and into carry.
- R6: A rotate copies sign, zero, AC and parity unchanged from `flagsIn`, even when its result is zero. Only carry changes.
- R7: `srcSel` decodes `opcode` combinationally. For the register forms of OR and SBB it is the low three opcode bits (0 = B, 1 = C, 2 = D, 3 = E, 4 = H, 5 = L, 6 = memory at HL, 7 = A). For the immediate forms it is 4'h8. For rotates and unsupported opcodes it is 4'hF.
- R8: When the operand source is A (8'hB7, 8'h9F), `accIn` is used as the operand and `operand` has no effect. All inputs are sampled on the accepting edge, and later changes have no effect.
- R9: Counting the accepting cycle as the first, `done` is high for exactly one cycle. That cycle is the 4th for register forms and rotates, and the 7th for the memory (low bits 6) and immediate forms. `accOut` and `flagsOut` change only on entry to that cycle.
- R10: While `busy` is high, `start` is ignored, and the operation in progress completes with its own result.
- R11: `start` with an unsupported opcode is ignored. `busy` and `done` stay low and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run `opcode` this cycle |
| opcode | input | 8 | Instruction opcode |
| accIn | input | 8 | Current accumulator |
| operand | input | 8 | Operand byte from register, memory or immediate |
| flagsIn | input | 8 | Current flags byte |
| srcSel | output | 4 | Decoded operand source |
| busy | output | 1 | Operation in progress, new starts ignored |
| done | output | 1 | One-cycle pulse: new results valid |
| accOut | output | 8 | Committed accumulator |
| flagsOut | output | 8 | Committed flags byte |

## Verification
The state that can go wrong is the T-state counter, the latched class and length, and the latched operand and flags bytes. A counter fault moves `done` off the 4th or 7th cycle at the first operation, and a stuck `busy` makes the next `start` disappear. A latch fault shows as a wrong `accOut` or `flagsOut` on the `done` cycle of the affected operation, for example when a rotate disturbs a kept flag or an A-source form picks up `operand`. The bench therefore changes inputs after acceptance, and it checks the cycle of `done` as well as the values.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

  // Flags byte bit positions; a neighbouring unit reads these fields.
  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_AC = 4;
  localparam int FLAG_P  = 2;
  localparam int FLAG_CY = 0;
  localparam logic [7:0] FLAG_MASK = 8'hD5;

  localparam logic [3:0] SRC_IMM  = 4'h8;
  localparam logic [3:0] SRC_NONE = 4'hF;
  localparam logic [2:0] SRC_MEM  = 3'd6;
  localparam logic [2:0] SRC_ACC  = 3'd7;

  typedef enum logic [2:0] {
    CLS_OR, CLS_SBB, CLS_RLC, CLS_RRC, CLS_RAL, CLS_RAR, CLS_NONE
  } opClass_e;

  typedef struct packed {
    opClass_e   cls;
    logic [3:0] src;
    logic       extLen;
  } decode_t;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic     load;    // latch inputs this edge
    logic     useAcc;  // valid with load: operand comes from A
    logic     commit;  // write outputs this edge
    opClass_e cls;     // valid with commit
  } strobes_t;

  function automatic decode_t decodeOp(input logic [7:0] op);
    decode_t d;
    d.cls    = CLS_NONE;
    d.src    = SRC_NONE;
    d.extLen = 1'b0;
    if (op[7:3] == 5'b10110) begin
      d.cls    = CLS_OR;
      d.src    = {1'b0, op[2:0]};
      d.extLen = (op[2:0] == SRC_MEM);
    end else if (op[7:3] == 5'b10011) begin
      d.cls    = CLS_SBB;
      d.src    = {1'b0, op[2:0]};
      d.extLen = (op[2:0] == SRC_MEM);
    end else begin
      case (op)
        8'hF6:   begin d.cls = CLS_OR;  d.src = SRC_IMM; d.extLen = 1'b1; end
        8'hDE:   begin d.cls = CLS_SBB; d.src = SRC_IMM; d.extLen = 1'b1; end
        8'h07:   d.cls = CLS_RLC;
        8'h0F:   d.cls = CLS_RRC;
        8'h17:   d.cls = CLS_RAL;
        8'h1F:   d.cls = CLS_RAR;
        default: d.cls = CLS_NONE;
      endcase
    end
    return d;
  endfunction

  function automatic logic isRotate(input opClass_e c);
    return (c == CLS_RLC) || (c == CLS_RRC) || (c == CLS_RAL) || (c == CLS_RAR);
  endfunction

  function automatic logic [7:0] packFlags(input logic s, input logic z,
                                           input logic ac, input logic p,
                                           input logic cy);
    logic [7:0] f;
    f = 8'h00;
    f[FLAG_S]  = s;
    f[FLAG_Z]  = z;
    f[FLAG_AC] = ac;
    f[FLAG_P]  = p;
    f[FLAG_CY] = cy;
    return f;
  endfunction

endpackage

// File: rtl/acc_alu_core.sv
`timescale 1ns/1ps
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  opClass_e          cls,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic [7:0]        flgIn,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flagsNew
);
  localparam int NIB_W = 4;

  logic              cyIn;
  logic [DATA_W:0]   diff;
  logic [NIB_W:0]    nibDiff;
  logic              sign;
  logic              zero;
  logic              parEven;

  assign cyIn = flgIn[FLAG_CY];

  always_comb begin
    diff    = {1'b0, aIn} - {1'b0, bIn} - {{DATA_W{1'b0}}, cyIn};
    nibDiff = {1'b0, aIn[NIB_W-1:0]} - {1'b0, bIn[NIB_W-1:0]} - {{NIB_W{1'b0}}, cyIn};
  end

  always_comb begin
    result = aIn;
    unique case (cls)
      CLS_OR:  result = aIn | bIn;
      CLS_SBB: result = diff[DATA_W-1:0];
      CLS_RLC: result = {aIn[DATA_W-2:0], aIn[DATA_W-1]};
      CLS_RRC: result = {aIn[0], aIn[DATA_W-1:1]};
      CLS_RAL: result = {aIn[DATA_W-2:0], cyIn};
      CLS_RAR: result = {cyIn, aIn[DATA_W-1:1]};
      default: result = aIn;
    endcase
  end

  assign sign    = result[DATA_W-1];
  assign zero    = (result == '0);
  assign parEven = ~^result;

  always_comb begin
    unique case (cls)
      CLS_OR:  flagsNew = packFlags(sign, zero, 1'b0, parEven, 1'b0);
      CLS_SBB: flagsNew = packFlags(sign, zero, nibDiff[NIB_W], parEven, diff[DATA_W]);
      CLS_RLC, CLS_RAL:
        flagsNew = packFlags(flgIn[FLAG_S], flgIn[FLAG_Z], flgIn[FLAG_AC],
                             flgIn[FLAG_P], aIn[DATA_W-1]);
      CLS_RRC, CLS_RAR:
        flagsNew = packFlags(flgIn[FLAG_S], flgIn[FLAG_Z], flgIn[FLAG_AC],
                             flgIn[FLAG_P], aIn[0]);
      default: flagsNew = flgIn & FLAG_MASK;
    endcase
  end

endmodule

// File: rtl/acc_alu_ctrl.sv
`timescale 1ns/1ps
module acc_alu_ctrl
  import acc_alu_pkg::*;
#(
  parameter int REG_TSTATES = 4,
  parameter int EXT_TSTATES = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] opcode,
  output logic [3:0] srcSel,
  output logic       busy,
  output logic       done,
  output strobes_t   stb
);
  localparam int MAX_T = (REG_TSTATES > EXT_TSTATES) ? REG_TSTATES : EXT_TSTATES;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] REG_LEN = CNT_W'(REG_TSTATES);
  localparam logic [CNT_W-1:0] EXT_LEN = CNT_W'(EXT_TSTATES);

  decode_t          dec;
  logic             accept;
  logic             commit;
  logic             active;
  logic             doneQ;
  logic [CNT_W-1:0] tCnt;
  logic [CNT_W-1:0] lenQ;
  logic [CNT_W-1:0] lastCnt;
  opClass_e         clsQ;

  always_comb dec = decodeOp(opcode);

  assign srcSel  = dec.src;
  assign accept  = start && !active && (dec.cls != CLS_NONE);
  // Accept edge ends T1; commit edge ends T(len-1); done shows in T(len).
  assign lastCnt = lenQ - CNT_W'(2);
  assign commit  = active && (tCnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      doneQ  <= 1'b0;
      tCnt   <= '0;
      lenQ   <= '0;
      clsQ   <= CLS_NONE;
    end else begin
      doneQ <= commit;
      if (accept) begin
        active <= 1'b1;
        tCnt   <= CNT_W'(1);
        lenQ   <= dec.extLen ? EXT_LEN : REG_LEN;
        clsQ   <= dec.cls;
      end else if (commit) begin
        active <= 1'b0;
        tCnt   <= '0;
      end else if (active) begin
        tCnt <= tCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    stb.load   = accept;
    stb.useAcc = (dec.src == {1'b0, SRC_ACC});
    stb.commit = commit;
    stb.cls    = clsQ;
  end

  assign busy = active;
  assign done = doneQ;

  // R9: counter stays inside the T-state window while active
  p_cnt_window_r9: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (tCnt != '0) && (tCnt <= lastCnt));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R10: an operation in flight keeps its class and length
  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (active && !commit) |=> active && $stable(clsQ) && $stable(lenQ));

  // R11: unsupported opcodes never start the sequencer
  p_reject_bad_r11: assert property (@(posedge clk) disable iff (!rstN)
    (start && !active && (dec.cls == CLS_NONE)) |=> !active);

endmodule

// File: rtl/acc_alu_dpath.sv
`timescale 1ns/1ps
module acc_alu_dpath
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic [7:0]        flagsIn,
  output logic [DATA_W-1:0] accOut,
  output logic [7:0]        flagsOut
);
  logic [DATA_W-1:0] aQ;
  logic [DATA_W-1:0] bQ;
  logic [7:0]        flgQ;
  logic [DATA_W-1:0] result;
  logic [7:0]        flagsNew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ   <= '0;
      bQ   <= '0;
      flgQ <= '0;
    end else if (stb.load) begin
      aQ   <= accIn;
      bQ   <= stb.useAcc ? accIn : operand;
      flgQ <= flagsIn;
    end
  end

  acc_alu_core #(.DATA_W(DATA_W)) u_core (
    .cls      (stb.cls),
    .aIn      (aQ),
    .bIn      (bQ),
    .flgIn    (flgQ),
    .result   (result),
    .flagsNew (flagsNew)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accOut   <= '0;
      flagsOut <= '0;
    end else if (stb.commit) begin
      accOut   <= result;
      flagsOut <= flagsNew;
    end
  end

  // R9: outputs move only on a commit edge
  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(accOut) && $stable(flagsOut));

  // R2: OR leaves both carry flags cleared
  p_or_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && stb.cls == CLS_OR) |=> !flagsOut[FLAG_AC] && !flagsOut[FLAG_CY]);

  // R2, R3: parity flag matches the committed accumulator
  p_parity_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && (stb.cls == CLS_OR || stb.cls == CLS_SBB))
      |=> flagsOut[FLAG_P] == ~^accOut);

  // R3: sign and zero match the committed accumulator
  p_sign_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && stb.cls == CLS_SBB)
      |=> flagsOut[FLAG_S] == accOut[DATA_W-1] && flagsOut[FLAG_Z] == (accOut == '0));

  // R6: rotates carry the four non-carry flags through unchanged
  p_rot_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && isRotate(stb.cls))
      |=> flagsOut[FLAG_S] == flgQ[FLAG_S] && flagsOut[FLAG_Z] == flgQ[FLAG_Z] &&
          flagsOut[FLAG_AC] == flgQ[FLAG_AC] && flagsOut[FLAG_P] == flgQ[FLAG_P]);

endmodule

// File: rtl/acc_alu_unit.sv
`timescale 1ns/1ps
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int REG_TSTATES = 4,
  parameter int EXT_TSTATES = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic [7:0]        flagsIn,
  output logic [3:0]        srcSel,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] accOut,
  output logic [7:0]        flagsOut
);
  strobes_t stb;

  acc_alu_ctrl #(
    .REG_TSTATES (REG_TSTATES),
    .EXT_TSTATES (EXT_TSTATES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opcode (opcode),
    .srcSel (srcSel),
    .busy   (busy),
    .done   (done),
    .stb    (stb)
  );

  acc_alu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .accIn    (accIn),
    .operand  (operand),
    .flagsIn  (flagsIn),
    .accOut   (accOut),
    .flagsOut (flagsOut)
  );

endmodule

// File: tb/acc_alu_unit_test.sv
`timescale 1ns/1ps
module acc_alu_unit_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       start;
  logic [7:0] opcode;
  logic [7:0] accIn;
  logic [7:0] operand;
  logic [7:0] flagsIn;
  logic [3:0] srcSel;
  logic       busy;
  logic       done;
  logic [7:0] accOut;
  logic [7:0] flagsOut;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  acc_alu_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .accIn(accIn),
    .operand(operand), .flagsIn(flagsIn), .srcSel(srcSel), .busy(busy),
    .done(done), .accOut(accOut), .flagsOut(flagsOut)
  );

  // {opcode, acc, operand, flagsIn, expected acc, expected flags}
  localparam int NV = 18;
  localparam logic [47:0] VEC [NV] = '{
    {8'hB0, 8'h12, 8'h21, 8'h11, 8'h33, 8'h04},
    {8'hB6, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h44},
    {8'hF6, 8'h80, 8'h01, 8'h01, 8'h81, 8'h84},
    {8'hB7, 8'h07, 8'hF0, 8'h00, 8'h07, 8'h00},
    {8'hB5, 8'h0F, 8'hF0, 8'h00, 8'hFF, 8'h84},
    {8'h98, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h14},
    {8'h9E, 8'h00, 8'h00, 8'h01, 8'hFF, 8'h95},
    {8'hDE, 8'h50, 8'h20, 8'h01, 8'h2F, 8'h10},
    {8'h9F, 8'h5A, 8'h33, 8'h01, 8'hFF, 8'h95},
    {8'h9A, 8'h44, 8'h44, 8'h00, 8'h00, 8'h44},
    {8'h17, 8'h80, 8'h00, 8'hD4, 8'h00, 8'hD5},
    {8'h17, 8'h01, 8'h00, 8'h01, 8'h03, 8'h00},
    {8'h17, 8'h40, 8'h00, 8'hFF, 8'h81, 8'hD4},
    {8'h1F, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01},
    {8'h1F, 8'h02, 8'h00, 8'h45, 8'h81, 8'h44},
    {8'h07, 8'h81, 8'h00, 8'h00, 8'h03, 8'h01},
    {8'h0F, 8'h01, 8'h00, 8'h81, 8'h80, 8'h81},
    {8'h0F, 8'h02, 8'h00, 8'h01, 8'h01, 8'h00}
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int expLen(input logic [7:0] op);
    if (op == 8'hB6 || op == 8'h9E || op == 8'hF6 || op == 8'hDE) return 7;
    return 4;
  endfunction

  function automatic logic [3:0] expSrc(input logic [7:0] op);
    if (op == 8'hF6 || op == 8'hDE) return 4'h8;
    if (op[7:3] == 5'b10110 || op[7:3] == 5'b10011) return {1'b0, op[2:0]};
    return 4'hF;
  endfunction

  function automatic string reqOf(input logic [7:0] op);
    if (op == 8'hB7 || op == 8'h9F) return "R8";
    if (op[7:3] == 5'b10110 || op == 8'hF6) return "R2";
    if (op[7:3] == 5'b10011 || op == 8'hDE) return "R3";
    if (op == 8'h17 || op == 8'h1F) return "R4";
    return "R5";
  endfunction

  // Drives one operation; returns edges after the accept edge until done.
  task automatic runOp(input logic [7:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] f,
                       output int edges, output logic early);
    logic [7:0] prevAcc;
    logic [7:0] prevFlg;
    @(negedge clk);
    prevAcc = accOut;
    prevFlg = flagsOut;
    opcode = op; accIn = a; operand = b; flagsIn = f; start = 1'b1;
    #1;
    check("R7", "srcSel", {12'h0, srcSel}, {12'h0, expSrc(op)});
    @(posedge clk);
    #1;
    start = 1'b0;
    accIn = 8'hA5; operand = 8'h5A; flagsIn = 8'h00;  // R8: late changes ignored
    edges = 0;
    early = 1'b0;
    while (edges < 20) begin
      @(posedge clk);
      #1;
      edges++;
      if (done) break;
      if (accOut !== prevAcc || flagsOut !== prevFlg) early = 1'b1;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int doneSeen;
    int busySeen;
    int edges;
    logic early;

    rstN = 1'b0; start = 1'b0; opcode = 8'h00;
    accIn = 8'h00; operand = 8'h00; flagsIn = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "accOut in reset", {8'h0, accOut}, 16'h0);
    check("R1", "flagsOut in reset", {8'h0, flagsOut}, 16'h0);
    check("R1", "busy/done in reset", {14'h0, busy, done}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1", "idle after reset", {6'h0, busy, done, accOut}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] op;
      logic [7:0] eAcc;
      logic [7:0] eFlg;
      op   = VEC[i][47:40];
      eAcc = VEC[i][15:8];
      eFlg = VEC[i][7:0];
      runOp(op, VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], edges, early);
      check("R9", "done edge count", 16'(edges), 16'(expLen(op) - 2));
      check("R9", "outputs held before done", {15'h0, early}, 16'h0);
      check(reqOf(op), "accOut", {8'h0, accOut}, {8'h0, eAcc});
      if (op == 8'h17 || op == 8'h1F || op == 8'h07 || op == 8'h0F)
        check("R6", "rotate flags", {8'h0, flagsOut}, {8'h0, eFlg});
      else
        check(reqOf(op), "flagsOut", {8'h0, flagsOut}, {8'h0, eFlg});
      @(posedge clk);
      #1;
      check("R9", "done single pulse", {15'h0, done}, 16'h0);
    end

    // R10: start held high while busy is ignored
    @(negedge clk);
    opcode = 8'hB0; accIn = 8'h01; operand = 8'h02; flagsIn = 8'h00; start = 1'b1;
    @(posedge clk);
    #1;
    opcode = 8'h9F; accIn = 8'h77;
    check("R10", "busy after accept", {15'h0, busy}, 16'h1);
    @(posedge clk);
    #1;
    @(posedge clk);
    #1;
    start = 1'b0;
    check("R10", "first op done", {15'h0, done}, 16'h1);
    check("R10", "first op result", {8'h0, accOut}, 16'h0003);
    doneSeen = 0;
    busySeen = 0;
    repeat (8) begin
      @(posedge clk);
      #1;
      if (done) doneSeen++;
      if (busy) busySeen++;
    end
    check("R10", "no second op", 16'(doneSeen + busySeen), 16'h0);

    // R11: unsupported opcode ignored
    @(negedge clk);
    opcode = 8'h00; accIn = 8'hEE; operand = 8'hEE; start = 1'b1;
    #1;
    check("R7", "srcSel for unsupported", {12'h0, srcSel}, 16'h000F);
    @(posedge clk);
    #1;
    start = 1'b0;
    doneSeen = 0;
    busySeen = 0;
    if (busy) busySeen++;
    repeat (8) begin
      @(posedge clk);
      #1;
      if (done) doneSeen++;
      if (busy) busySeen++;
    end
    check("R11", "no busy/done", 16'(doneSeen + busySeen), 16'h0);
    check("R11", "accOut held", {8'h0, accOut}, 16'h0003);

    // R1: reset in the middle of an operation
    runOp(8'hF6, 8'h0F, 8'hF0, 8'h00, edges, early);
    check("R2", "ORI result", {8'h0, accOut}, 16'h00FF);
    @(negedge clk);
    opcode = 8'h9E; accIn = 8'h33; operand = 8'h11; start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1", "mid-op reset outputs", {accOut, flagsOut}, 16'h0);
    check("R1", "mid-op reset busy", {15'h0, busy}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    check("R1", "no late done after reset", {7'h0, done, accOut}, 16'h0);

    summary();
    $finish;
  end

endmodule